// File: doc/BRIEF.md
# Latency Down-Counter Trigger Matcher

This block holds a small pool of buffered hits for one pixel region. A hit is written into a free slot picked by the write address. At that moment the slot takes a copy of a free-running external time counter as its arrival stamp. The slot then counts the trigger latency down on its own. When its countdown expires, the slot looks at the trigger input in that single cycle. If the trigger is high, the hit is kept and offered on the output stream. If the trigger is low, the slot frees itself at once.

Each slot makes its own matching decision, so no timestamps are compared at the head of a queue. Matched hits leave through a valid/ready stream that carries the arrival stamp and the slot index. The downstream reader uses that index as its read address. When several slots are matched, the lowest index goes first. Once an offer has been made while ready is low, it is frozen: its index and stamp stay the same until it is accepted, even if a slot with a lower index becomes matched in the meantime. On acceptance the slot returns to free on the same clock edge. Per-slot occupancy and matched flags are exported as plain status vectors.

Top module: `lat_trig_matcher`

## Requirements
- R1: After reset every slot is free, `cell_busy` and `cell_trig` are all zero and `out_valid` is low.
- R2: When `wr_en` is high in a cycle and slot `wr_addr` is free, only that slot becomes occupied at the next edge. It stores the value of `ext_count` from that cycle as its arrival stamp.
- R3: A written slot stays occupied and unmatched through the LATENCY-1 cycles that follow the write cycle. It samples `trigger` in exactly the cycle LATENCY cycles after its write cycle.
- R4: If `trigger` is high in a slot's sampling cycle, the slot's bit in `cell_trig` goes high at the next edge. The slot's stamp is then offered on the output stream.
- R5: If `trigger` is low in a slot's sampling cycle, the slot is free at the next edge and its hit is never offered.
- R6: A write aimed at a slot that is not free is ignored. The slot's stamp and timing are unchanged.
- R7: When no offer is frozen, the offered slot (`out_index`) is the lowest-indexed matched slot.
- R8: Back-pressure: while `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_index` and `out_toa` stay stable on the following cycles.
- R9: A transfer (`out_valid` and `out_ready` both high) frees the offered slot at that edge. `cell_busy` and `cell_trig` drop for it in the next cycle.
- R10: Bit i of `cell_busy` is high exactly when slot i is not free. Bit i of `cell_trig` is high exactly when slot i is matched and waiting to be sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_count | input | TOA_W | Free-running time counter |
| trigger | input | 1 | Trigger level, sampled by expiring slots |
| wr_en | input | 1 | Region write strobe for a new hit |
| wr_addr | input | $clog2(NUM_CELLS) | Slot index targeted by the write |
| cell_busy | output | NUM_CELLS | Per-slot occupied flags |
| cell_trig | output | NUM_CELLS | Per-slot matched flags |
| out_valid | output | 1 | A matched hit is offered |
| out_ready | input | 1 | Downstream accepts the offered hit |
| out_toa | output | TOA_W | Arrival stamp of the offered hit |
| out_index | output | $clog2(NUM_CELLS) | Slot index of the offered hit, used as read address |

## Verification
Single writes with the trigger aimed at exactly the sampling cycle separate a correct countdown length from an off-by-one. Writes that are not followed by a trigger show that unmatched hits are dropped. A second write to an occupied slot shows that a write cannot overwrite a pending stamp. Three slots matched out of order while ready is low tell the frozen-offer rule apart from plain lowest-index priority. A long random mix of writes, trigger levels and ready stalls is compared cycle by cycle against a reference model. This catches interactions between freeing, rewriting and arbitration that the directed cases miss.

// File: rtl/ltm_pkg.sv
package ltm_pkg;
  typedef enum logic [1:0] {
    SLOT_FREE = 2'd0,
    SLOT_WAIT = 2'd1,
    SLOT_HIT  = 2'd2
  } slot_state_e;
endpackage

// File: rtl/ltm_wr_decode.sv
module ltm_wr_decode #(
  parameter int NUM_CELLS = 8,
  localparam int AW = (NUM_CELLS > 1) ? $clog2(NUM_CELLS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  output logic [NUM_CELLS-1:0] cell_we
);
  for (genvar g = 0; g < NUM_CELLS; g++) begin : g_dec
    assign cell_we[g] = wr_en && (wr_addr == AW'(g));
  end

  // R2: at most one slot is written per cycle
  a_r2_one_write: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cell_we));
endmodule

// File: rtl/ltm_cell.sv
module ltm_cell
  import ltm_pkg::*;
#(
  parameter int TOA_W   = 16,
  parameter int LATENCY = 400,
  localparam int CW = (LATENCY > 1) ? $clog2(LATENCY) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [TOA_W-1:0] ext_count,
  input  logic             trigger,
  input  logic             grant,
  output logic             busy,
  output logic             hit,
  output logic [TOA_W-1:0] toa
);
  slot_state_e     state_q;
  logic [CW-1:0]   cnt_q;
  logic [TOA_W-1:0] toa_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SLOT_FREE;
      cnt_q   <= '0;
      toa_q   <= '0;
    end else begin
      unique case (state_q)
        SLOT_FREE: begin
          if (we) begin
            state_q <= SLOT_WAIT;
            cnt_q   <= CW'(LATENCY - 1);
            toa_q   <= ext_count;
          end
        end
        SLOT_WAIT: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
          end else if (trigger) begin
            state_q <= SLOT_HIT;
          end else begin
            state_q <= SLOT_FREE;
          end
        end
        SLOT_HIT: begin
          if (grant) state_q <= SLOT_FREE;
        end
        default: state_q <= SLOT_FREE;
      endcase
    end
  end

  assign busy = (state_q != SLOT_FREE);
  assign hit  = (state_q == SLOT_HIT);
  assign toa  = toa_q;

  // R2: a write into a free slot captures the time stamp
  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && we) |=> (busy && !hit && toa == $past(ext_count)));
  // R6: a write into an occupied slot leaves its stamp alone
  a_r6_ignore_write: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(toa));
  // R4: expiry with trigger leads to the matched state
  a_r4_match: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !hit && cnt_q == '0 && trigger) |=> hit);
  // R5: expiry without trigger frees the slot
  a_r5_discard: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !hit && cnt_q == '0 && !trigger) |=> !busy);
  // R3: the countdown does not stall or jump while waiting
  a_r3_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !hit && cnt_q != '0) |=> (busy && !hit && cnt_q == $past(cnt_q) - 1'b1));
  // R9: a granted matched slot is free at the next cycle
  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && grant) |=> !busy);
  // R9: a grant only ever reaches a matched slot
  a_r9_grant_hit: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> hit);
endmodule

// File: rtl/ltm_out_select.sv
module ltm_out_select #(
  parameter int NUM_CELLS = 8,
  localparam int AW = (NUM_CELLS > 1) ? $clog2(NUM_CELLS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CELLS-1:0] hit_vec,
  input  logic                 out_ready,
  output logic                 out_valid,
  output logic [AW-1:0]        sel_idx,
  output logic [NUM_CELLS-1:0] grant_vec
);
  logic          any_hit;
  logic [AW-1:0] pri_idx;
  logic          hold_q;
  logic [AW-1:0] hold_idx_q;

  always_comb begin
    any_hit = 1'b0;
    pri_idx = '0;
    for (int i = NUM_CELLS - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        any_hit = 1'b1;
        pri_idx = AW'(i);
      end
    end
  end

  assign sel_idx   = hold_q ? hold_idx_q : pri_idx;
  assign out_valid = hold_q || any_hit;

  for (genvar g = 0; g < NUM_CELLS; g++) begin : g_grant
    assign grant_vec[g] = out_valid && out_ready && (sel_idx == AW'(g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q     <= 1'b0;
      hold_idx_q <= '0;
    end else if (out_valid && !out_ready) begin
      hold_q     <= 1'b1;
      hold_idx_q <= sel_idx;
    end else if (out_valid && out_ready) begin
      hold_q     <= 1'b0;
    end
  end

  // R8: a stalled offer keeps its slot
  a_r8_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(sel_idx)));
  // R9: one grant per transfer
  a_r9_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |-> $onehot(grant_vec));
  // R7: an offered slot is always matched
  a_r7_offer_is_hit: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> hit_vec[sel_idx]);
endmodule

// File: rtl/lat_trig_matcher.sv
module lat_trig_matcher #(
  parameter int NUM_CELLS = 8,
  parameter int TOA_W     = 16,
  parameter int LATENCY   = 400,
  localparam int AW = (NUM_CELLS > 1) ? $clog2(NUM_CELLS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [TOA_W-1:0]     ext_count,
  input  logic                 trigger,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  output logic [NUM_CELLS-1:0] cell_busy,
  output logic [NUM_CELLS-1:0] cell_trig,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [TOA_W-1:0]     out_toa,
  output logic [AW-1:0]        out_index
);
  logic [NUM_CELLS-1:0]            cell_we;
  logic [NUM_CELLS-1:0]            grant_vec;
  logic [NUM_CELLS-1:0][TOA_W-1:0] toa_all;

  ltm_wr_decode #(.NUM_CELLS(NUM_CELLS)) u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .cell_we (cell_we)
  );

  for (genvar g = 0; g < NUM_CELLS; g++) begin : g_cell
    ltm_cell #(.TOA_W(TOA_W), .LATENCY(LATENCY)) u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (cell_we[g]),
      .ext_count (ext_count),
      .trigger   (trigger),
      .grant     (grant_vec[g]),
      .busy      (cell_busy[g]),
      .hit       (cell_trig[g]),
      .toa       (toa_all[g])
    );
  end

  ltm_out_select #(.NUM_CELLS(NUM_CELLS)) u_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit_vec   (cell_trig),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .sel_idx   (out_index),
    .grant_vec (grant_vec)
  );

  assign out_toa = toa_all[out_index];

  // R8: stamp on a stalled offer does not change
  a_r8_toa_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(out_toa));
  // R10: a matched slot is always counted as occupied
  a_r10_trig_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_trig & ~cell_busy) == '0);
  // R9: the transferred slot is released
  a_r9_slot_freed: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> !cell_busy[$past(out_index)]);
endmodule

// File: tb/lat_trig_matcher_tb.sv
module lat_trig_matcher_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N   = 8;
  localparam int TW  = 16;
  localparam int LAT = 12;
  localparam int AW  = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [TW-1:0] ext_count = '0;
  logic          trigger = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic          out_ready = 1'b0;
  logic [N-1:0]  cell_busy, cell_trig;
  logic          out_valid;
  logic [TW-1:0] out_toa;
  logic [AW-1:0] out_index;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // reference model
  int          m_state [N];
  int          m_rem   [N];
  logic [TW-1:0] m_toa [N];
  bit          m_lock;
  int          m_lidx;

  always #(CLK_PERIOD/2) clk = ~clk;

  lat_trig_matcher #(.NUM_CELLS(N), .TOA_W(TW), .LATENCY(LAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .ext_count(ext_count), .trigger(trigger),
    .wr_en(wr_en), .wr_addr(wr_addr), .cell_busy(cell_busy), .cell_trig(cell_trig),
    .out_valid(out_valid), .out_ready(out_ready), .out_toa(out_toa), .out_index(out_index)
  );

  function automatic bit exp_valid();
    if (m_lock) return 1'b1;
    for (int i = 0; i < N; i++) if (m_state[i] == 2) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int exp_idx();
    if (m_lock) return m_lidx;
    for (int i = 0; i < N; i++) if (m_state[i] == 2) return i;
    return 0;
  endfunction

  function automatic logic [N-1:0] exp_busy();
    logic [N-1:0] v = '0;
    for (int i = 0; i < N; i++) v[i] = (m_state[i] != 0);
    return v;
  endfunction

  function automatic logic [N-1:0] exp_trig();
    logic [N-1:0] v = '0;
    for (int i = 0; i < N; i++) v[i] = (m_state[i] == 2);
    return v;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin m_state[i] = 0; m_rem[i] = 0; m_toa[i] = '0; end
    m_lock = 0; m_lidx = 0;
  endtask

  task automatic model_step();
    bit v = exp_valid();
    int s = exp_idx();
    bit hs = v && out_ready;
    if (v && !out_ready) begin m_lock = 1; m_lidx = s; end
    else if (hs) m_lock = 0;
    for (int i = 0; i < N; i++) begin
      case (m_state[i])
        0: if (wr_en && wr_addr == AW'(i)) begin
             m_state[i] = 1; m_rem[i] = LAT - 1; m_toa[i] = ext_count;
           end
        1: if (m_rem[i] > 0) m_rem[i]--;
           else m_state[i] = trigger ? 2 : 0;
        default: if (hs && s == i) m_state[i] = 0;
      endcase
    end
  endtask

  task automatic compare_all();
    chk(cell_busy == exp_busy(), "R10 busy flags", cell_busy, exp_busy());
    chk(cell_trig == exp_trig(), "R4 matched flags", cell_trig, exp_trig());
    chk(out_valid == exp_valid(), "R4 out_valid", out_valid, exp_valid());
    if (exp_valid()) begin
      chk(out_index == AW'(exp_idx()), "R7 out_index", out_index, exp_idx());
      chk(out_toa == m_toa[exp_idx()], "R2 out_toa", out_toa, m_toa[exp_idx()]);
    end
  endtask

  // one cycle: inputs already set at negedge; model advances; compare at next negedge
  task automatic step(input bit we, input int addr, input bit trg, input bit rdy);
    wr_en = we; wr_addr = AW'(addr); trigger = trg; out_ready = rdy;
    model_step();
    @(posedge clk);
    @(negedge clk);
    ext_count = ext_count + 1'b1;
    cyc++;
    compare_all();
  endtask

  task automatic idle(input int n, input bit rdy);
    for (int k = 0; k < n; k++) step(0, 0, 0, rdy);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [TW-1:0] first_stamp;
    void'($urandom(32'd1234));
    model_reset();
    ext_count = 16'h1000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(cell_busy == '0 && cell_trig == '0, "R1 flags after reset", {cell_busy, cell_trig}, 0);
    chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    rst_n = 1'b1;

    // R2/R3/R4/R9: single hit, trigger exactly in its sampling cycle
    first_stamp = ext_count;
    step(1, 3, 0, 1);
    chk(cell_busy == 8'b0000_1000, "R2 only slot 3 written", cell_busy, 8'h08);
    idle(LAT - 1, 1);
    chk(cell_busy[3] && !cell_trig[3], "R3 still waiting before sampling", {cell_busy[3], cell_trig[3]}, 2);
    step(0, 0, 1, 0);
    chk(cell_trig[3] && out_valid, "R4 matched after trigger", {cell_trig[3], out_valid}, 3);
    chk(out_toa == first_stamp, "R2 captured stamp", out_toa, first_stamp);
    idle(3, 0);
    chk(out_valid && out_index == 3 && out_toa == first_stamp, "R8 stalled offer stable", out_index, 3);
    step(0, 0, 0, 1);
    chk(!cell_busy[3] && !out_valid, "R9 slot freed after transfer", cell_busy[3], 0);

    // R5: no trigger at sampling cycle
    step(1, 1, 0, 1);
    idle(LAT - 1, 1);
    step(0, 0, 0, 1);
    chk(!cell_busy[1] && !out_valid, "R5 unmatched hit discarded", {cell_busy[1], out_valid}, 0);

    // R6: rewrite of an occupied slot ignored
    first_stamp = ext_count;
    step(1, 2, 0, 1);
    step(0, 0, 0, 1);
    step(1, 2, 0, 1);
    idle(LAT - 3, 1);
    step(0, 0, 1, 0);
    chk(out_valid && out_toa == first_stamp, "R6 stamp kept after rewrite", out_toa, first_stamp);
    step(0, 0, 1, 1);
    chk(!out_valid && cell_busy == '0, "R6 rewrite made no second hit", cell_busy, 0);

    // R7/R8: slots 6,2,4 matched while stalled; 6 frozen, then 2 before 4
    step(1, 6, 0, 0);
    step(1, 2, 0, 0);
    step(1, 4, 0, 0);
    idle(LAT - 3, 0);
    step(0, 0, 1, 0);
    step(0, 0, 1, 0);
    step(0, 0, 1, 0);
    chk(out_index == 6 && cell_trig == 8'b0101_0100, "R8 frozen offer kept over lower index", out_index, 6);
    step(0, 0, 0, 1);
    chk(out_valid && out_index == 2, "R7 lowest matched index next", out_index, 2);
    step(0, 0, 0, 1);
    chk(out_valid && out_index == 4, "R7 remaining slot served", out_index, 4);
    step(0, 0, 0, 1);
    chk(!out_valid && cell_busy == '0, "R9 all slots free", cell_busy, 0);

    // random mix checked against the model every cycle
    for (int k = 0; k < 4000; k++) begin
      step(($urandom % 100) < 35, int'($urandom % N), ($urandom % 100) < 55,
           ($urandom % 100) < 65);
    end
    idle(LAT + 2, 1);
    chk(cell_busy == '0 && !out_valid, "R9 drained after random run", cell_busy, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule